// File: doc/BRIEF.md
# Dual Timer Clock Source Unit

This block produces the count-enable strobes for two 16-bit timer/counters that share one system clock. Software sets up two items over a simple write port: a 5-bit prescaler value N and a byte-wide source-select word. The select word holds a 3-bit source code for each counter. Each counter can be stopped, or it can advance on one of four sources. The first is a tick from the prescaler, which divides the system clock by N+1. The second is a rising edge on the shared event input `tb_in`. The third is a prescaler tick that falls while `tb_in` is high, which accumulates pulse width. The fourth is a rising edge on the slow-clock input `slow_in`.

Each counter has a source controller built as a small state machine. Its states are SRC_OFF, SRC_PRESC, SRC_EVENT, SRC_PULSE and SRC_SLOW. Reset forces SRC_OFF. A write to the select word moves the controller to the state that its code decodes to. Code 000 and the reserved codes lead to SRC_OFF. When no select write occurs, the controller stays in its current state. The output process turns the current state into a one-cycle enable strobe, and the strobe advances that counter's count register. Software can load either count register directly. The count registers have no reset.

Top module: `dual_timer_clksrc`

## Requirements
- R1: Reset clears the prescaler value to 0 and places both source controllers in SRC_OFF. After reset, neither `cntN_en` is asserted and neither count changes until a select word is written.
- R2: Reset does not alter the count registers. Writes to a count register take effect even while reset is active.
- R3: A write with `wr_addr`=0 loads N from `wr_data[4:0]`, and bits 7:5 are ignored. The write restarts the divider. In mode 001 the counter advances once every N+1 cycles, and the first advance comes N cycles after the cycle that follows the write.
- R4: A write with `wr_addr`=1 sets counter 1's code from `wr_data[2:0]` and counter 2's code from `wr_data[5:3]`. Bits 7:6 are ignored. Codes: 000 stop, 001 prescaled, 010 event, 011 pulse-accumulate, 100 slow.
- R5: Codes 000, 101, 110 and 111 produce no strobes. Writing 000 to a running counter freezes its count.
- R6: In code 010, `tb_in` passes through a two-flop synchronizer, and the counter advances once for each rising edge of the synchronized level. A level that stays high does not advance the counter. Pulses must last at least two cycles high and two cycles low.
- R7: In code 011, the counter advances on each prescaler tick that falls while the synchronized `tb_in` is high.
- R8: In code 100, the counter advances once for each synchronized rising edge of `slow_in`.
- R9: Each strobe adds one to the count, and the count wraps from FFFFh to 0000h.
- R10: A write with `wr_addr`=2 loads counter 1 and a write with `wr_addr`=3 loads counter 2, each from `wr_data[15:0]`. The written value appears in the next cycle. If a strobe falls in the same cycle as the write, the write wins and the strobe is dropped.
- R11: `cntN_en` is high in exactly the cycles in which the count advances, and each event or slow-clock edge produces a strobe one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 prescaler, 1 select word, 2 count 1, 3 count 2 |
| wr_data | input | 16 | Write data |
| tb_in | input | 1 | Asynchronous event / gate input |
| slow_in | input | 1 | Asynchronous slow-clock input |
| cnt1_en | output | 1 | Counter 1 advance strobe |
| cnt2_en | output | 1 | Counter 2 advance strobe |
| cnt1_val | output | 16 | Counter 1 value |
| cnt2_val | output | 16 | Counter 2 value |

## Verification
A software load of a count register and an advance strobe for that same counter can land in the same cycle. The bench provokes this by running counter 1 from the prescaled source with N=0, so a strobe arrives every cycle, and then loading a value while the counter runs. The outcome passes if the loaded value appears unchanged in the next cycle and the count then rises by exactly one in the cycle after. The same approach, with FFFFh as the loaded value, checks the wrap to zero.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int CNT_W   = 16;
    localparam int PS_W    = 5;
    localparam int CODE_W  = 3;
    localparam int ADDR_W  = 2;
    localparam int N_CH    = 2;

    localparam logic [ADDR_W-1:0] A_PRESC = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEL   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT1  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT2  = 2'd3;

    localparam logic [CODE_W-1:0] C_STOP  = 3'b000;
    localparam logic [CODE_W-1:0] C_PRESC = 3'b001;
    localparam logic [CODE_W-1:0] C_EVENT = 3'b010;
    localparam logic [CODE_W-1:0] C_PULSE = 3'b011;
    localparam logic [CODE_W-1:0] C_SLOW  = 3'b100;

    typedef enum logic [2:0] {
        SRC_OFF,
        SRC_PRESC,
        SRC_EVENT,
        SRC_PULSE,
        SRC_SLOW
    } src_mode_e;

    function automatic src_mode_e decode_src(input logic [CODE_W-1:0] code);
        src_mode_e m;
        unique case (code)
            C_PRESC: m = SRC_PRESC;
            C_EVENT: m = SRC_EVENT;
            C_PULSE: m = SRC_PULSE;
            C_SLOW:  m = SRC_SLOW;
            default: m = SRC_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int PS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PS_W-1:0] load_val,
    output logic            tick
);

    logic [PS_W-1:0] div_q;
    logic [PS_W-1:0] down_q;

    // Programmed divisor minus one; cleared by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (load) begin
            div_q <= load_val;
        end
    end

    // Down-counter: reloads on write or on reaching zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            down_q <= '0;
        end else if (load) begin
            down_q <= load_val;
        end else if (down_q == '0) begin
            down_q <= div_q;
        end else begin
            down_q <= down_q - 1'b1;
        end
    end

    assign tick = (down_q == '0);

    // R3
    presc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (down_q == $past(div_q)));

    // R3
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && div_q != '0) |=> !tick);

endmodule

// File: rtl/tcs_sync_edge.sv
module tcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tcs_channel.sv
module tcs_channel
    import tcs_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [CODE_W-1:0] sel_code,
    input  logic              tick,
    input  logic              ev_level,
    input  logic              ev_rise,
    input  logic              slow_rise,
    input  logic              cnt_wr,
    input  logic [CW-1:0]     cnt_wdata,
    output logic              cnt_en,
    output logic [CW-1:0]     cnt_q
);

    src_mode_e mode_q;
    src_mode_e mode_d;

    // Next-state logic: a select write jumps to the decoded source.
    always_comb begin
        mode_d = mode_q;
        if (sel_wr) begin
            mode_d = decode_src(sel_code);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SRC_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Output process: one strobe per qualifying event.
    always_comb begin
        unique case (mode_q)
            SRC_OFF:   cnt_en = 1'b0;
            SRC_PRESC: cnt_en = tick;
            SRC_EVENT: cnt_en = ev_rise;
            SRC_PULSE: cnt_en = tick & ev_level;
            SRC_SLOW:  cnt_en = slow_rise;
            default:   cnt_en = 1'b0;
        endcase
    end

    // Count register: no reset; software load has priority.
    always_ff @(posedge clk) begin
        if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (cnt_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && !$isunknown(cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));

    // R5
    reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (sel_code == C_STOP || sel_code > C_SLOW)) |=> !cnt_en);

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRC_OFF && !cnt_wr && !$isunknown(cnt_q)) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_timer_clksrc.sv
module dual_timer_clksrc
    import tcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tb_in,
    input  logic              slow_in,
    output logic              cnt1_en,
    output logic              cnt2_en,
    output logic [CNT_W-1:0]  cnt1_val,
    output logic [CNT_W-1:0]  cnt2_val
);

    logic              presc_load;
    logic              sel_wr;
    logic              tick;
    logic              tb_level;
    logic              tb_rise;
    logic              slow_level;
    logic              slow_rise;
    logic [N_CH-1:0]   ch_en;
    logic [N_CH-1:0]   ch_wr;
    logic [CNT_W-1:0]  ch_cnt [N_CH];

    assign presc_load = wr_en && (wr_addr == A_PRESC);
    assign sel_wr     = wr_en && (wr_addr == A_SEL);
    assign ch_wr[0]   = wr_en && (wr_addr == A_CNT1);
    assign ch_wr[1]   = wr_en && (wr_addr == A_CNT2);

    tcs_prescaler #(.PS_W(PS_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (presc_load),
        .load_val (wr_data[PS_W-1:0]),
        .tick     (tick)
    );

    tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_tb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tb_in),
        .level    (tb_level),
        .rise     (tb_rise)
    );

    tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_slow_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_in),
        .level    (slow_level),
        .rise     (slow_rise)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tcs_channel #(.CW(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_wr    (sel_wr),
            .sel_code  (wr_data[i*CODE_W +: CODE_W]),
            .tick      (tick),
            .ev_level  (tb_level),
            .ev_rise   (tb_rise),
            .slow_rise (slow_rise),
            .cnt_wr    (ch_wr[i]),
            .cnt_wdata (wr_data),
            .cnt_en    (ch_en[i]),
            .cnt_q     (ch_cnt[i])
        );
    end

    assign cnt1_en  = ch_en[0];
    assign cnt2_en  = ch_en[1];
    assign cnt1_val = ch_cnt[0];
    assign cnt2_val = ch_cnt[1];

    // R8
    slow_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_rise |-> slow_level);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(cnt1_en || cnt2_en));

endmodule

// File: tb/tb_dual_timer_clksrc.sv
`timescale 1ns/1ps
module tb_dual_timer_clksrc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tb_in = 1'b0;
    logic        slow_in = 1'b0;
    logic        cnt1_en, cnt2_en;
    logic [15:0] cnt1_val, cnt2_val;

    int total = 0;
    int bad   = 0;
    int en1_seen = 0;
    int en2_seen = 0;

    always #2 clk = ~clk;

    dual_timer_clksrc dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tb_in(tb_in), .slow_in(slow_in),
        .cnt1_en(cnt1_en), .cnt2_en(cnt2_en),
        .cnt1_val(cnt1_val), .cnt2_val(cnt2_val)
    );

    // {presc[7:0], code[2:0], tb level, cycles[7:0], expected count[15:0]}
    localparam int NV = 13;
    localparam logic [35:0] VEC [NV] = '{
        {8'h00, 3'b001, 1'b0, 8'd20, 16'd20},
        {8'h01, 3'b001, 1'b0, 8'd20, 16'd10},
        {8'h03, 3'b001, 1'b0, 8'd20, 16'd5},
        {8'h04, 3'b001, 1'b0, 8'd20, 16'd4},
        {8'h1F, 3'b001, 1'b0, 8'd64, 16'd2},
        {8'h21, 3'b001, 1'b0, 8'd20, 16'd10},
        {8'h00, 3'b000, 1'b0, 8'd20, 16'd0},
        {8'h00, 3'b101, 1'b0, 8'd20, 16'd0},
        {8'h00, 3'b111, 1'b0, 8'd20, 16'd0},
        {8'h01, 3'b011, 1'b1, 8'd20, 16'd10},
        {8'h00, 3'b011, 1'b0, 8'd20, 16'd0},
        {8'h00, 3'b010, 1'b1, 8'd20, 16'd0},
        {8'h00, 3'b100, 1'b0, 8'd20, 16'd0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller sits at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            en1_seen += int'(cnt1_en);
            en2_seen += int'(cnt2_en);
        end
    endtask

    initial begin
        int watch = 0;
        while (watch < 150000) begin
            @(posedge clk);
            watch++;
        end
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] held;
        // R2: loads accepted while reset is active.
        @(negedge clk);
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'h4321);
        wr(2'd1, 16'h0009);
        run(2);
        rst_n = 1'b1;
        en1_seen = 0; en2_seen = 0;
        run(10);
        // R1: idle after reset, select write during reset ignored
        check("R1 en1 idle", 16'(en1_seen), 16'd0);
        check("R1 en2 idle", 16'(en2_seen), 16'd0);
        check("R2 cnt1 loaded in reset", cnt1_val, 16'h1234);
        check("R2 cnt2 loaded in reset", cnt2_val, 16'h4321);

        // Vector walk on counter 1; counter 2 stays stopped.
        for (int v = 0; v < NV; v++) begin
            tb_in = VEC[v][24];
            run(4);
            wr(2'd3, 16'hA5A5);
            wr(2'd0, {8'h00, VEC[v][35:28]});
            wr(2'd1, {8'h00, 2'b11, 3'b000, VEC[v][27:25]});
            wr(2'd2, 16'h0000);
            run(int'(VEC[v][23:16]));
            // R3 R4 R5 R7 R6 R8 per vector row
            check($sformatf("R3/R4/R5/R6/R7/R8 vec%0d cnt1", v), cnt1_val, VEC[v][15:0]);
            check($sformatf("R4 vec%0d cnt2 untouched", v), cnt2_val, 16'hA5A5);
        end
        tb_in = 1'b0;
        run(4);

        // R6: five event pulses on counter 1, strobes one cycle each (R11)
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0000);
        en1_seen = 0;
        for (int p = 0; p < 5; p++) begin
            tb_in = 1'b1; run(3);
            tb_in = 1'b0; run(3);
        end
        run(4);
        check("R6 event count", cnt1_val, 16'd5);
        check("R11 event strobe cycles", 16'(en1_seen), 16'd5);

        // R8: slow clock on counter 2, counter 1 stopped
        wr(2'd2, 16'h0042);
        wr(2'd1, 16'h0020);
        wr(2'd3, 16'h0000);
        en2_seen = 0;
        for (int p = 0; p < 4; p++) begin
            slow_in = 1'b1; run(4);
            slow_in = 1'b0; run(4);
        end
        run(4);
        check("R8 slow count", cnt2_val, 16'd4);
        check("R11 slow strobe cycles", 16'(en2_seen), 16'd4);
        check("R5 cnt1 stopped", cnt1_val, 16'h0042);

        // R10: load collides with an every-cycle strobe
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0001);
        run(3);
        check("R11 en1 high at divisor 1", 16'(cnt1_en), 16'd1);
        wr(2'd2, 16'h0100);
        check("R10 load wins", cnt1_val, 16'h0100);
        run(1);
        check("R10 advance after load", cnt1_val, 16'h0101);

        // R9: wrap
        wr(2'd2, 16'hFFFF);
        check("R9 pre-wrap", cnt1_val, 16'hFFFF);
        run(1);
        check("R9 wrap to zero", cnt1_val, 16'h0000);

        // R11: divisor 4 gives one strobe in four cycles
        wr(2'd0, 16'h0003);
        run(1);
        en1_seen = 0;
        run(8);
        check("R11 strobe density N=3", 16'(en1_seen), 16'd2);

        // R5: stop freezes the count
        wr(2'd1, 16'h0000);
        held = cnt1_val;
        run(10);
        check("R5 stop freezes", cnt1_val, held);

        // R2/R1: reset while running keeps count, clears divisor
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0001);
        run(5);
        wr(2'd0, 16'h0003);
        rst_n = 1'b0;
        held = cnt1_val;
        run(3);
        check("R2 frozen during reset", cnt1_val, held);
        rst_n = 1'b1;
        en1_seen = 0;
        run(3);
        check("R2 kept over reset", cnt1_val, held);
        check("R1 no strobe after reset", 16'(en1_seen), 16'd0);
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'h0000);
        run(10);
        check("R1 divisor cleared by reset", cnt1_val, 16'd10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule